// File: doc/BRIEF.md
# Bus-Master IDE Descriptor DMA Engine

This block is the bus-master DMA engine of one IDE channel. Software programs a 32-bit pointer to a table of physical region descriptors and then sets the start bit in the command register. The engine reads one descriptor at a time over a 16-bit memory port. It then moves 16-bit words between the memory region that descriptor names and a device-side word stream. The direction is chosen at start: either from the device into memory or from memory to the device.

When the device signals its final word, or when the descriptor space runs out, the engine compares the descriptor space with the size of the device transfer. It reports the result in three status flags: active, interrupt and error. A table longer than the transfer leaves the engine parked with active still set, and software must clear start to release it. Clearing start during a transfer halts the engine at once. A table that never sets its end flag is cut off after a fixed number of entries.

Top module: `ide_busmaster_dma`

## Requirements
- R1: After reset the registers at offsets 0, 2 and 4 all read 0, and memRead, memWrite and devAck are all low.
- R2: Register offsets are 0 for command, 2 for status and 4 for the table pointer. In the command register, bit 0 is start and bit 3 is direction (1 means device to memory). In the status register, bit 0 is active, bit 1 is error and bit 2 is interrupt. The table pointer is 32 bits wide and its two low bits read as 0.
- R3: Writing command bit 0 as 1 while start is 0 sets active on the next cycle. The engine then reads the descriptor as four halfwords, little-endian, at pointer+0, +2, +4 and +6. Bits 31:0 are the region address. Bits 47:32 are the byte count. Bit 63 marks the end of the table.
- R4: In direction 1, each devAck writes devData to memory at consecutive even addresses. The first address is the region address with bit 0 cleared.
- R5: In direction 0, each word is read from memory and appears on devWdata together with devAck one cycle after the read.
- R6: Bit 0 of the byte count is ignored. A count that is 0 after masking means 65536 bytes.
- R7: If the descriptors exactly cover the device transfer, the engine ends with interrupt set and active clear.
- R8: If descriptor space remains when the device signals its last word (bytes left in the current entry, or further entries), interrupt and active are both set and no further word moves. A later stop clears active and leaves interrupt set.
- R9: If the table ends before the device's last word, active and interrupt end clear, error is set, and no further devAck follows.
- R10: Writing command bit 0 as 0 while start is 1 clears active on the next cycle, moves no word in that cycle or afterwards, and leaves interrupt unchanged.
- R11: Writing 1 to status bit 2 clears interrupt and writing 1 to bit 1 clears error. Writing 0 to either bit has no effect.
- R12: After MAX_PRD entries without an end flag, the last entry is treated as final.
- R13: Each following descriptor is read 8 bytes after the previous one, and its words go to its own region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on regAddr) |
| memRead | output | 1 | Memory read request; data is due on the next cycle |
| memWrite | output | 1 | Memory write request |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, one cycle after memRead |
| devReq | input | 1 | Device offers (direction 1) or wants (direction 0) a word |
| devLast | input | 1 | The current device word is the last of the transfer |
| devData | input | 16 | Word from the device |
| devAck | output | 1 | A word moves at this clock edge |
| devWdata | output | 16 | Word to the device |

## Verification
A register write takes effect at the next rising edge. The status that follows the final device word is therefore readable at the falling edge right after the edge on which devAck was high, and the bench reads it there. Descriptor fetch takes five cycles after start, and each word then takes one cycle in direction 1 or two cycles in direction 0. The device model holds its inputs from one falling edge to the next and counts a word only when devAck is high just after its inputs settle. The bench then checks the memory contents, the received words, the access counts and the status against the descriptor sizes it placed in the table.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam logic [2:0] OFF_CMD  = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd2;
  localparam logic [2:0] OFF_BASE = 3'd4;

  typedef struct packed {
    logic loadTable;
    logic nextEntry;
    logic fetchStep;
    logic wordStep;
    logic selData;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_XFER, ST_RDWAIT, ST_HOLD
  } engState_t;
endpackage

// File: rtl/bmdma_datapath.sv
module bmdma_datapath
  import bmdma_pkg::*;
#(
  parameter int MAX_PRD = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strb,
  input  logic        baseWe,
  input  logic [29:0] baseWdata,
  input  logic [15:0] memRdata,
  input  logic [15:0] devData,
  output logic [31:0] prdBase,
  output logic [31:0] memAddr,
  output logic [15:0] memWdata,
  output logic [15:0] devWdata,
  output logic        fetchLast,
  output logic        remainLast,
  output logic        finalEntry
);
  localparam int ENT_W = (MAX_PRD > 1) ? $clog2(MAX_PRD) : 1;
  localparam logic [ENT_W-1:0] LAST_ENT = ENT_W'(MAX_PRD - 1);

  logic [31:0]      tablePtr, curAddr;
  logic [ENT_W-1:0] entryCnt;
  logic [2:0]       fetchIdx;
  logic [15:0]      half0, half1, half2;
  logic             eotFlag;
  logic [16:0]      remain;
  logic [15:0]      evenCount;
  logic [16:0]      regionBytes;

  assign evenCount   = half2 & 16'hfffe;
  assign regionBytes = (evenCount == 16'd0) ? 17'h10000 : {1'b0, evenCount};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prdBase  <= '0;
      tablePtr <= '0;
      entryCnt <= '0;
      fetchIdx <= '0;
      half0    <= '0;
      half1    <= '0;
      half2    <= '0;
      eotFlag  <= 1'b0;
      curAddr  <= '0;
      remain   <= '0;
    end else begin
      if (baseWe) prdBase <= {baseWdata, 2'b00};
      if (strb.loadTable) begin
        tablePtr <= prdBase;
        entryCnt <= '0;
        fetchIdx <= '0;
      end else if (strb.nextEntry) begin
        tablePtr <= tablePtr + 32'd8;
        entryCnt <= entryCnt + 1'b1;
        fetchIdx <= '0;
      end else if (strb.fetchStep) begin
        fetchIdx <= fetchIdx + 3'd1;
        case (fetchIdx)
          3'd1: half0 <= memRdata;
          3'd2: half1 <= memRdata;
          3'd3: half2 <= memRdata;
          3'd4: begin
            curAddr <= {half1, half0} & 32'hffff_fffe;
            remain  <= regionBytes;
            eotFlag <= memRdata[15];
          end
          default: ;
        endcase
      end else if (strb.wordStep) begin
        curAddr <= curAddr + 32'd2;
        remain  <= remain - 17'd2;
      end
    end
  end

  assign memAddr    = strb.selData ? curAddr : tablePtr + {28'd0, fetchIdx, 1'b0};
  assign memWdata   = devData;
  assign devWdata   = memRdata;
  assign fetchLast  = (fetchIdx == 3'd4);
  assign remainLast = (remain == 17'd2);
  assign finalEntry = eotFlag || (entryCnt == LAST_ENT);
endmodule

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [2:0] regAddr,
  input  logic [3:0] regWdata,
  input  logic       devReq,
  input  logic       devLast,
  input  logic       fetchLast,
  input  logic       remainLast,
  input  logic       finalEntry,
  output dpStrobe_t  strb,
  output logic       memRead,
  output logic       memWrite,
  output logic       devAck,
  output logic       startBit,
  output logic       dirBit,
  output logic       statActive,
  output logic       statErr,
  output logic       statIntr
);
  engState_t state, nxtState;
  logic cmdWr, statWr, startReq, stopReq;
  logic wordDone, setIntr, setErr, clrActive;

  assign cmdWr    = regWe && (regAddr == OFF_CMD);
  assign statWr   = regWe && (regAddr == OFF_STAT);
  assign startReq = cmdWr && regWdata[0] && !startBit;
  assign stopReq  = cmdWr && !regWdata[0] && startBit;

  always_comb begin
    strb      = '0;
    memRead   = 1'b0;
    memWrite  = 1'b0;
    devAck    = 1'b0;
    wordDone  = 1'b0;
    setIntr   = 1'b0;
    setErr    = 1'b0;
    clrActive = 1'b0;
    nxtState  = state;
    case (state)
      ST_FETCH: begin
        strb.fetchStep = 1'b1;
        memRead = !fetchLast;
        if (fetchLast) nxtState = ST_XFER;
      end
      ST_XFER: begin
        strb.selData = 1'b1;
        if (devReq) begin
          if (dirBit) begin
            devAck   = 1'b1;
            memWrite = 1'b1;
            wordDone = 1'b1;
          end else begin
            memRead  = 1'b1;
            nxtState = ST_RDWAIT;
          end
        end
      end
      ST_RDWAIT: begin
        strb.selData = 1'b1;
        devAck   = 1'b1;
        wordDone = 1'b1;
        nxtState = ST_XFER;
      end
      default: ;
    endcase
    if (wordDone) begin
      strb.wordStep = 1'b1;
      if (devLast) begin
        setIntr = 1'b1;
        if (remainLast && finalEntry) begin
          clrActive = 1'b1;
          nxtState  = ST_IDLE;
        end else begin
          nxtState = ST_HOLD;
        end
      end else if (remainLast) begin
        if (finalEntry) begin
          setErr    = 1'b1;
          clrActive = 1'b1;
          nxtState  = ST_IDLE;
        end else begin
          strb.nextEntry = 1'b1;
          nxtState = ST_FETCH;
        end
      end
    end
    if (stopReq) begin
      strb     = '0;
      memRead  = 1'b0;
      memWrite = 1'b0;
      devAck   = 1'b0;
      setIntr  = 1'b0;
      setErr   = 1'b0;
      nxtState = ST_IDLE;
    end else if (startReq) begin
      strb.loadTable = 1'b1;
      nxtState = ST_FETCH;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      startBit   <= 1'b0;
      dirBit     <= 1'b0;
      statActive <= 1'b0;
      statErr    <= 1'b0;
      statIntr   <= 1'b0;
    end else begin
      state <= nxtState;
      if (cmdWr) startBit <= regWdata[0];
      if (startReq) dirBit <= regWdata[3];
      if (startReq) statActive <= 1'b1;
      else if (stopReq || clrActive) statActive <= 1'b0;
      if (setIntr) statIntr <= 1'b1;
      else if (statWr && regWdata[2]) statIntr <= 1'b0;
      if (setErr) statErr <= 1'b1;
      else if (statWr && regWdata[1]) statErr <= 1'b0;
    end
  end
endmodule

// File: rtl/ide_busmaster_dma.sv
module ide_busmaster_dma
  import bmdma_pkg::*;
#(
  parameter int MAX_PRD = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        memRead,
  output logic        memWrite,
  output logic [31:0] memAddr,
  output logic [15:0] memWdata,
  input  logic [15:0] memRdata,
  input  logic        devReq,
  input  logic        devLast,
  input  logic [15:0] devData,
  output logic        devAck,
  output logic [15:0] devWdata
);
  dpStrobe_t   strb;
  logic        fetchLast, remainLast, finalEntry;
  logic        startBit, dirBit, statActive, statErr, statIntr;
  logic [31:0] prdBase;

  bmdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata[3:0]), .devReq(devReq), .devLast(devLast),
    .fetchLast(fetchLast), .remainLast(remainLast), .finalEntry(finalEntry),
    .strb(strb), .memRead(memRead), .memWrite(memWrite), .devAck(devAck),
    .startBit(startBit), .dirBit(dirBit), .statActive(statActive),
    .statErr(statErr), .statIntr(statIntr)
  );

  bmdma_datapath #(.MAX_PRD(MAX_PRD)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .baseWe(regWe && (regAddr == OFF_BASE)), .baseWdata(regWdata[31:2]),
    .memRdata(memRdata), .devData(devData), .prdBase(prdBase),
    .memAddr(memAddr), .memWdata(memWdata), .devWdata(devWdata),
    .fetchLast(fetchLast), .remainLast(remainLast), .finalEntry(finalEntry)
  );

  always_comb begin
    case (regAddr)
      OFF_CMD:  regRdata = {28'd0, dirBit, 2'b00, startBit};
      OFF_STAT: regRdata = {29'd0, statIntr, statErr, statActive};
      OFF_BASE: regRdata = prdBase;
      default:  regRdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/bmdma_checker.sv
module bmdma_checker (
  input logic       clk,
  input logic       rstN,
  input logic       regWe,
  input logic [2:0] regAddr,
  input logic       cmdStart,
  input logic       memRead,
  input logic       memWrite,
  input logic       memAddr0,
  input logic       devAck,
  input logic       active,
  input logic       intr,
  input logic       err
);
  a_r10_stop_clears_active: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 3'd0 && !cmdStart) |=> !active);

  a_r3_active_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> $past(regWe && regAddr == 3'd0 && cmdStart));

  a_r4_no_mem_collision: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));

  a_r4_even_write_addr: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> !memAddr0);

  a_r7_end_reports: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(active) && !$past(regWe && regAddr == 3'd0 && !cmdStart)) |-> (intr || err));

  a_r9_ack_only_active: assert property (@(posedge clk) disable iff (!rstN)
    devAck |-> active);
endmodule

bind ide_busmaster_dma bmdma_checker u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .cmdStart(regWdata[0]), .memRead(memRead), .memWrite(memWrite),
  .memAddr0(memAddr[0]), .devAck(devAck), .active(statActive),
  .intr(statIntr), .err(statErr)
);

// File: tb/ide_busmaster_dma_tb.sv
module ide_busmaster_dma_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic        memRead, memWrite;
  logic [31:0] memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata = 16'd0;
  logic        devReq = 1'b0, devLast = 1'b0;
  logic [15:0] devData = 16'd0;
  logic        devAck;
  logic [15:0] devWdata;

  logic [15:0] mem [0:2047];
  logic        preWe = 1'b0;
  logic [10:0] preIdx = 11'd0;
  logic [15:0] preData = 16'd0;
  int          nWrites = 0, nReads = 0, nAcks = 0;
  logic [31:0] readLog [0:63];
  logic [15:0] rx [0:63];
  int          checks = 0, fails = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  ide_busmaster_dma #(.MAX_PRD(4)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memRead(memRead),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .devReq(devReq), .devLast(devLast),
    .devData(devData), .devAck(devAck), .devWdata(devWdata)
  );

  always @(posedge clk) begin
    if (preWe) mem[preIdx] <= preData;
    else if (memWrite) mem[memAddr[11:1]] <= memWdata;
    if (memRead) begin
      memRdata <= mem[memAddr[11:1]];
      readLog[nReads % 64] <= memAddr;
      nReads <= nReads + 1;
    end
    if (memWrite) nWrites <= nWrites + 1;
    if (devAck) nAcks <= nAcks + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] addr, input logic [15:0] d);
    @(negedge clk);
    preWe = 1'b1; preIdx = addr[11:1]; preData = d;
    @(negedge clk);
    preWe = 1'b0;
  endtask

  task automatic putDesc(input logic [31:0] tbl, input int idx, input logic [31:0] a,
                         input logic [15:0] cnt, input bit eot);
    logic [31:0] p;
    p = tbl + 32'(idx * 8);
    poke(p, a[15:0]);
    poke(p + 2, a[31:16]);
    poke(p + 4, cnt);
    poke(p + 6, {eot, 15'd0});
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic devRun(input int n, input logic [15:0] seed, input bit markLast,
                        input int limit, output int acks);
    acks = 0;
    for (int c = 0; c < limit && acks < n; c++) begin
      @(negedge clk);
      devReq = 1'b1;
      devData = seed + 16'(acks);
      devLast = markLast && (acks == n - 1);
      #1;
      if (devAck) begin
        if (acks < 64) rx[acks] = devWdata;
        acks++;
      end
    end
    @(negedge clk);
    devReq = 1'b0; devLast = 1'b0;
  endtask

  task automatic launch(input logic [31:0] tbl, input bit toMem);
    wr(3'd0, 32'd0);
    wr(3'd2, 32'd6);
    wr(3'd4, tbl);
    wr(3'd0, toMem ? 32'h9 : 32'h1);
  endtask

  task automatic testReset();
    logic [31:0] d;
    rd(3'd0, d); chk("R1 cmd reset", d, 0);
    rd(3'd2, d); chk("R1 status reset", d, 0);
    rd(3'd4, d); chk("R1 base reset", d, 0);
    chk("R1 idle ports", {29'd0, memRead, memWrite, devAck}, 0);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    wr(3'd4, 32'h1234_5677);
    rd(3'd4, d); chk("R2 base low bits", d, 32'h1234_5674);
  endtask

  task automatic testExactToMem();
    logic [31:0] d;
    int acks, r0;
    putDesc(32'h100, 0, 32'h201, 16'd8, 1'b1);
    r0 = nReads;
    launch(32'h100, 1'b1);
    rd(3'd2, d); chk("R3 active after start", d, 32'h1);
    rd(3'd0, d); chk("R2 cmd readback", d, 32'h9);
    devRun(4, 16'hA000, 1'b1, 40, acks);
    chk("R4 ack count", acks, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R3 fetch address", readLog[(r0 + i) % 64], 32'h100 + 32'(2 * i));
      chk("R4 memory word", {16'd0, mem[11'h100 + 11'(i)]}, {16'd0, 16'hA000 + 16'(i)});
    end
    rd(3'd2, d); chk("R7 exact status", d, 32'h4);
    wr(3'd2, 32'h2);
    rd(3'd2, d); chk("R11 error bit write keeps intr", d, 32'h4);
    wr(3'd2, 32'h4);
    rd(3'd2, d); chk("R11 intr cleared", d, 32'h0);
  endtask

  task automatic testExactFromMem();
    logic [31:0] d;
    int acks;
    poke(32'h300, 16'h11A1); poke(32'h302, 16'h22B2); poke(32'h304, 16'h33C3);
    putDesc(32'h100, 0, 32'h300, 16'd6, 1'b1);
    launch(32'h100, 1'b0);
    devRun(3, 16'h0, 1'b1, 40, acks);
    chk("R5 ack count", acks, 3);
    chk("R5 word0", {16'd0, rx[0]}, 32'h11A1);
    chk("R5 word1", {16'd0, rx[1]}, 32'h22B2);
    chk("R5 word2", {16'd0, rx[2]}, 32'h33C3);
    rd(3'd2, d); chk("R7 exact status mem to dev", d, 32'h4);
  endtask

  task automatic testLonger();
    logic [31:0] d;
    int acks, w0, r0, a0;
    putDesc(32'h100, 0, 32'h400, 16'd16, 1'b1);
    launch(32'h100, 1'b1);
    devRun(4, 16'hB000, 1'b1, 40, acks);
    rd(3'd2, d); chk("R8 longer status", d, 32'h5);
    w0 = nWrites; r0 = nReads; a0 = nAcks;
    devRun(2, 16'hB100, 1'b1, 10, acks);
    chk("R8 parked acks", acks, 0);
    chk("R8 parked memory", nWrites + nReads + nAcks, w0 + r0 + a0);
    wr(3'd0, 32'h0);
    rd(3'd2, d); chk("R8 after stop", d, 32'h4);
  endtask

  task automatic testChain();
    logic [31:0] d;
    int acks;
    putDesc(32'h100, 0, 32'h400, 16'd4, 1'b0);
    putDesc(32'h100, 1, 32'h500, 16'd4, 1'b1);
    launch(32'h100, 1'b1);
    devRun(4, 16'hC000, 1'b1, 60, acks);
    chk("R13 ack count", acks, 4);
    chk("R13 region A", {mem[11'h201], mem[11'h200]}, 32'hC001_C000);
    chk("R13 region B", {mem[11'h281], mem[11'h280]}, 32'hC003_C002);
    rd(3'd2, d); chk("R7 chained exact", d, 32'h4);
    launch(32'h100, 1'b1);
    devRun(2, 16'hC100, 1'b1, 40, acks);
    rd(3'd2, d); chk("R8 more entries left", d, 32'h5);
    wr(3'd0, 32'h0);
  endtask

  task automatic testShort();
    logic [31:0] d;
    int acks;
    putDesc(32'h100, 0, 32'h600, 16'd4, 1'b1);
    launch(32'h100, 1'b1);
    devRun(5, 16'hD000, 1'b1, 30, acks);
    chk("R9 acks stop at table end", acks, 2);
    rd(3'd2, d); chk("R9 short status", d, 32'h2);
    wr(3'd2, 32'h4);
    rd(3'd2, d); chk("R11 intr write keeps error", d, 32'h2);
    wr(3'd2, 32'h0);
    rd(3'd2, d); chk("R11 zero write no effect", d, 32'h2);
    wr(3'd2, 32'h2);
    rd(3'd2, d); chk("R11 error cleared", d, 32'h0);
  endtask

  task automatic testSizes();
    logic [31:0] d;
    int acks;
    putDesc(32'h100, 0, 32'h700, 16'd7, 1'b1);
    launch(32'h100, 1'b1);
    devRun(3, 16'hE000, 1'b1, 40, acks);
    rd(3'd2, d); chk("R6 odd count masked", d, 32'h4);
    putDesc(32'h100, 0, 32'h800, 16'd0, 1'b1);
    launch(32'h100, 1'b1);
    devRun(32768, 16'h0, 1'b1, 33000, acks);
    chk("R6 zero count words", acks, 32768);
    rd(3'd2, d); chk("R6 zero means 65536", d, 32'h4);
  endtask

  task automatic testStopMid();
    logic [31:0] d;
    int acks, w0;
    putDesc(32'h100, 0, 32'h900, 16'd16, 1'b1);
    launch(32'h100, 1'b1);
    devRun(2, 16'hF000, 1'b0, 30, acks);
    chk("R10 words before stop", acks, 2);
    wr(3'd0, 32'h0);
    rd(3'd2, d); chk("R10 stop status", d, 32'h0);
    w0 = nWrites;
    devRun(3, 16'hF100, 1'b0, 10, acks);
    chk("R10 no ack after stop", acks, 0);
    chk("R10 no write after stop", nWrites, w0);
  endtask

  task automatic testLimit();
    logic [31:0] d;
    int acks;
    for (int i = 0; i < 4; i++) putDesc(32'h100, i, 32'hA00 + 32'(16 * i), 16'd2, 1'b0);
    putDesc(32'h100, 4, 32'hB00, 16'd16, 1'b1);
    launch(32'h100, 1'b1);
    devRun(6, 16'h5000, 1'b1, 80, acks);
    chk("R12 entry cap acks", acks, 4);
    rd(3'd2, d); chk("R12 entry cap status", d, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    testExactToMem();
    testExactFromMem();
    testLonger();
    testChain();
    testShort();
    testSizes();
    testStopMid();
    testLimit();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule